// File: doc/BRIEF.md
# Unaligned Load Splitter and Aligner

This block sits between a load requester and a memory bus that only moves whole, 4-byte-aligned words. The bus address carries no byte-select bits: it is the word index, that is, the byte address divided by four. A requester presents a byte address and an access size of 8, 16 or 32 bits. The block works out whether the requested bytes fit inside one bus word.

If they fit, it reads that one word, moves the wanted bytes down to bit 0, and returns them zero-extended. If the bytes cross into the next word, it reads both words one after the other. It moves the low word down by the byte offset and the high word up by the remaining byte count, then ORs the two into one right-justified result. A trap input changes how misaligned requests are handled: instead of being served, they get an error response without any bus activity.

Only one request is in flight at a time. The block is ready again on the cycle after it delivers a response.

Top module: `unaligned_load_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `bus_rd` are 0.
- R2: The first bus read of a request uses word address `req_addr[31:2]`. While `bus_rd` is high and `bus_ack` is low, both `bus_rd` and `bus_waddr` hold their values.
- R3: Size codes are 0 for 8-bit, 1 for 16-bit, and 2 or 3 for 32-bit. A load whose bytes lie inside one word takes exactly one bus read. Its result holds the addressed byte in bits 7:0 and higher addresses in higher bytes (little-endian), with all bits above the access size set to 0.
- R4: A load whose byte offset plus its size in bytes exceeds 4 takes exactly two bus reads. The second read goes to the word address one above the first. The result is assembled little-endian from the tail of the first word and the head of the second.
- R5: An 8-bit load is never misaligned. A 16-bit load is misaligned when address bit 0 is 1. A 32-bit load is misaligned when address bits 1:0 are not both 0.
- R6: With `trap_mode` set, a misaligned request performs no bus read and responds with `rsp_err` = 1 and `rsp_data` = 0.
- R7: With `trap_mode` set, an aligned request is served normally, with `rsp_err` = 0.
- R8: With `trap_mode` clear, `rsp_err` is always 0, and misaligned requests are served by split or shifted reads.
- R9: `req_ready` is 0 from the cycle after acceptance until the response. `rsp_valid` is high for exactly one cycle, and only after the last bus read has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_mode | input | 1 | 1: misaligned requests return an error |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_addr | input | 32 | Byte address of the load |
| req_size | input | 2 | 0 byte, 1 half, 2 or 3 word |
| bus_rd | output | 1 | Bus read request, held until acknowledged |
| bus_waddr | output | 30 | Word address of the bus read |
| bus_ack | input | 1 | Read data valid this cycle |
| bus_rdata | input | 32 | Aligned word returned by the bus |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Right-justified, zero-extended load data |
| rsp_err | output | 1 | Misaligned request refused in trap mode |

## Verification
A wrong byte offset or size held inside the block shows up as wrong or misplaced bytes in `rsp_data` on the response cycle. This is visible two to four cycles after the request. A wrong split decision shows at the bus within one read: a missing or surplus second read, or a second word address that is not the first plus one. A faulty fault flag shows on the response cycle as a spurious or missing `rsp_err`, or for trapped requests as any `bus_rd` activity at all.

// File: rtl/ula_pkg.sv
package ula_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BYTES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(BYTES);
    localparam int WA_W   = ADDR_W - OFF_W;
    localparam int CNT_W  = OFF_W + 1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } ld_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_RSP  = 2'd3
    } ld_state_e;

    typedef struct packed {
        logic [WA_W-1:0]  waddr;
        logic [OFF_W-1:0] off;
        ld_size_e         size;
        logic             split;
        logic             fault;
    } ld_req_t;

    // number of bytes an access of the given size touches
    function automatic logic [CNT_W-1:0] size_bytes(input ld_size_e sz);
        case (sz)
            SZ_BYTE: size_bytes = CNT_W'(1);
            SZ_HALF: size_bytes = CNT_W'(2);
            default: size_bytes = CNT_W'(BYTES);
        endcase
    endfunction

    // natural alignment test: offset must be a multiple of the size
    function automatic logic is_misaligned(input logic [OFF_W-1:0] off, input ld_size_e sz);
        logic [CNT_W-1:0] n;
        logic [CNT_W-1:0] m;
        n = size_bytes(sz);
        m = n - CNT_W'(1);
        is_misaligned = (({1'b0, off} & m) != '0);
    endfunction

    // the access runs past the end of its first word
    function automatic logic is_split(input logic [OFF_W-1:0] off, input ld_size_e sz);
        logic [CNT_W:0] last;
        last = {2'b00, off} + {1'b0, size_bytes(sz)};
        is_split = (last > (CNT_W+1)'(BYTES));
    endfunction

    function automatic logic [DATA_W-1:0] byte_mask(input ld_size_e sz);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (i < int'(size_bytes(sz))) m[i*8 +: 8] = 8'hFF;
        end
        byte_mask = m;
    endfunction

    function automatic logic [DATA_W-1:0] align_low(input logic [DATA_W-1:0] w,
                                                   input logic [OFF_W-1:0] off);
        int sh;
        sh = int'(off) * 8;
        align_low = w >> sh;
    endfunction

    function automatic logic [DATA_W-1:0] align_high(input logic [DATA_W-1:0] w,
                                                    input logic [OFF_W-1:0] off);
        int sh;
        sh = (BYTES - int'(off)) * 8;
        if (sh >= DATA_W) align_high = '0;
        else              align_high = w << sh;
    endfunction

endpackage

// File: rtl/ula_classify.sv
module ula_classify
    import ula_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [WA_W-1:0]   waddr,
    output logic [OFF_W-1:0]  off,
    output logic              misaligned,
    output logic              split
);
    ld_size_e sz;

    always_comb begin
        sz         = ld_size_e'(size);
        waddr      = addr[ADDR_W-1:OFF_W];
        off        = addr[OFF_W-1:0];
        misaligned = is_misaligned(off, sz);
        split      = is_split(off, sz);
    end

    // R5
    always_comb begin
        if (split) misaligned_split_chk: assert (misaligned);
    end
endmodule

// File: rtl/ula_ctrl.sv
module ula_ctrl
    import ula_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_mode,
    input  logic              req_valid,
    input  logic [1:0]        req_size,
    input  logic [WA_W-1:0]   dec_waddr,
    input  logic [OFF_W-1:0]  dec_off,
    input  logic              dec_mis,
    input  logic              dec_split,
    input  logic              bus_ack,
    output logic              req_ready,
    output logic              bus_rd,
    output logic [WA_W-1:0]   bus_waddr,
    output logic              ld_lo,
    output logic              ld_hi,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [OFF_W-1:0]  cur_off,
    output ld_size_e          cur_size,
    output logic              cur_fault
);
    ld_state_e state;
    ld_req_t   r;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            r     <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    r.waddr <= dec_waddr;
                    r.off   <= dec_off;
                    r.size  <= ld_size_e'(req_size);
                    r.split <= dec_split;
                    r.fault <= trap_mode && dec_mis;
                    state   <= (trap_mode && dec_mis) ? ST_RSP : ST_LO;
                end
                ST_LO:  if (bus_ack) state <= r.split ? ST_HI : ST_RSP;
                ST_HI:  if (bus_ack) state <= ST_RSP;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        bus_rd    = (state == ST_LO) || (state == ST_HI);
        bus_waddr = (state == ST_HI) ? r.waddr + WA_W'(1) : r.waddr;
        ld_lo     = (state == ST_LO) && bus_ack;
        ld_hi     = (state == ST_HI) && bus_ack;
        rsp_valid = (state == ST_RSP);
        rsp_err   = (state == ST_RSP) && r.fault;
        cur_off   = r.off;
        cur_size  = r.size;
        cur_fault = r.fault;
    end

    // R2
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_ack) |=> (bus_rd && $stable(bus_waddr)));

    // R4
    second_word_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_lo && r.split) |=> (bus_rd && bus_waddr == $past(bus_waddr) + WA_W'(1)));

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || rsp_valid) |-> !req_ready);
endmodule

// File: rtl/ula_merge.sv
module ula_merge
    import ula_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [OFF_W-1:0]  off,
    input  ld_size_e          size,
    input  logic              fault,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] rsp_data
);
    logic [DATA_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst)        acc <= '0;
        else if (ld_lo) acc <= align_low(bus_rdata, off);
        else if (ld_hi) acc <= acc | align_high(bus_rdata, off);
    end

    always_comb begin
        rsp_data = fault ? '0 : (acc & byte_mask(size));
    end

    // R4
    load_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ld_lo, ld_hi}));
endmodule

// File: rtl/unaligned_load_unit.sv
module unaligned_load_unit
    import ula_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        trap_mode,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_size,
    output logic        bus_rd,
    output logic [29:0] bus_waddr,
    input  logic        bus_ack,
    input  logic [31:0] bus_rdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_data,
    output logic        rsp_err
);
    logic [WA_W-1:0]  dec_waddr;
    logic [OFF_W-1:0] dec_off;
    logic             dec_mis;
    logic             dec_split;
    logic             ld_lo;
    logic             ld_hi;
    logic [OFF_W-1:0] cur_off;
    ld_size_e         cur_size;
    logic             cur_fault;

    ula_classify u_cls (
        .addr       (req_addr),
        .size       (req_size),
        .waddr      (dec_waddr),
        .off        (dec_off),
        .misaligned (dec_mis),
        .split      (dec_split)
    );

    ula_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .trap_mode (trap_mode),
        .req_valid (req_valid),
        .req_size  (req_size),
        .dec_waddr (dec_waddr),
        .dec_off   (dec_off),
        .dec_mis   (dec_mis),
        .dec_split (dec_split),
        .bus_ack   (bus_ack),
        .req_ready (req_ready),
        .bus_rd    (bus_rd),
        .bus_waddr (bus_waddr),
        .ld_lo     (ld_lo),
        .ld_hi     (ld_hi),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .cur_off   (cur_off),
        .cur_size  (cur_size),
        .cur_fault (cur_fault)
    );

    ula_merge u_merge (
        .clk       (clk),
        .rst       (rst),
        .ld_lo     (ld_lo),
        .ld_hi     (ld_hi),
        .off       (cur_off),
        .size      (cur_size),
        .fault     (cur_fault),
        .bus_rdata (bus_rdata),
        .rsp_data  (rsp_data)
    );

    // R6
    trap_nobus_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && trap_mode && dec_mis) |=> (!bus_rd && rsp_valid && rsp_err));

    // R8
    err_needs_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !trap_mode) |=> !rsp_err);
endmodule

// File: tb/unaligned_load_unit_test.sv
module unaligned_load_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;
    // {byte address, size code, trap}
    localparam logic [34:0] VEC [NVEC] = '{
        {32'h0000_0100, 2'd2, 1'b0},
        {32'h0000_0101, 2'd2, 1'b0},
        {32'h0000_0102, 2'd2, 1'b0},
        {32'h0000_0103, 2'd2, 1'b0},
        {32'h0000_0105, 2'd1, 1'b0},
        {32'h0000_0107, 2'd1, 1'b0},
        {32'h0000_0106, 2'd1, 1'b0},
        {32'h0000_010B, 2'd0, 1'b0},
        {32'h0000_010E, 2'd3, 1'b0},
        {32'h0000_0201, 2'd2, 1'b1},
        {32'h0000_0205, 2'd1, 1'b1},
        {32'h0000_0208, 2'd2, 1'b1},
        {32'h0000_020F, 2'd0, 1'b1},
        {32'h0000_03FE, 2'd1, 1'b1}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic        trap_mode = 0;
    logic        req_valid = 0;
    logic        req_ready;
    logic [31:0] req_addr = 0;
    logic [1:0]  req_size = 0;
    logic        bus_rd;
    logic [29:0] bus_waddr;
    logic        bus_ack = 0;
    logic [31:0] bus_rdata = 0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_err;

    int checks = 0;
    int fails = 0;
    int rd_cnt = 0;
    logic [29:0] rd_log [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    unaligned_load_unit uut (
        .clk(clk), .rst(rst), .trap_mode(trap_mode),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size),
        .bus_rd(bus_rd), .bus_waddr(bus_waddr),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] b);
        return 8'(b * 37 + 11) ^ b[15:8];
    endfunction

    function automatic logic [31:0] mem_word(input logic [29:0] wa);
        logic [31:0] w;
        for (int i = 0; i < 4; i++) w[i*8 +: 8] = mem_byte({wa, 2'(i)});
        return w;
    endfunction

    // bus model: acknowledge every held read one cycle later
    always @(posedge clk) begin
        if (rst) begin
            bus_ack <= 1'b0;
        end else begin
            if (bus_rd && bus_ack) begin
                rd_log[rd_cnt % 8] = bus_waddr;
                rd_cnt = rd_cnt + 1;
            end
            bus_ack   <= bus_rd && !bus_ack;
            bus_rdata <= mem_word(bus_waddr);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [31:0] a, input logic [1:0] s, input logic t);
        int n;
        logic mis;
        logic spl;
        logic [31:0] exp;
        int c0;
        int waits;
        n   = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
        mis = (n == 2 && a[0]) || (n == 4 && a[1:0] != 2'b00);
        spl = (int'(a[1:0]) + n) > 4;
        exp = 0;
        for (int i = 0; i < n; i++) exp[i*8 +: 8] = mem_byte(a + 32'(i));
        @(negedge clk);
        req_valid = 1; req_addr = a; req_size = s; trap_mode = t;
        c0 = rd_cnt;
        @(negedge clk);
        req_valid = 0;
        check("R9 ready low after accept", 32'(req_ready), 32'd0);
        waits = 0;
        while (!rsp_valid && waits < 50) begin
            @(negedge clk);
            waits++;
        end
        check("R9 response arrives", 32'(rsp_valid), 32'd1);
        if (t && mis) begin
            check("R6 error flag", 32'(rsp_err), 32'd1);
            check("R6 data zero", rsp_data, 32'd0);
            check("R6 no bus read", 32'(rd_cnt - c0), 32'd0);
        end else begin
            check(t ? "R7 no error" : "R8 no error", 32'(rsp_err), 32'd0);
            check(spl ? "R4 assembled data" : "R3 data", rsp_data, exp);
            check(spl ? "R4 two reads" : "R3 one read", 32'(rd_cnt - c0), spl ? 32'd2 : 32'd1);
            check("R2 first word address", 32'(rd_log[c0 % 8]), 32'(a[31:2]));
            if (spl) check("R4 second word address", 32'(rd_log[(c0 + 1) % 8]), 32'(a[31:2]) + 32'd1);
        end
        @(negedge clk);
        check("R9 single-cycle response", 32'(rsp_valid), 32'd0);
        check("R9 ready again", 32'(req_ready), 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        check("R1 ready after reset", 32'(req_ready), 32'd1);
        check("R1 no response after reset", 32'(rsp_valid), 32'd0);
        check("R1 no bus read after reset", 32'(bus_rd), 32'd0);
        for (int i = 0; i < NVEC; i++) begin
            do_load(VEC[i][34:3], VEC[i][2:1], VEC[i][0]);
        end
        // R5 byte loads at every offset never trap
        for (int k = 0; k < 4; k++) do_load(32'h0000_0400 + 32'(k), 2'd0, 1'b1);
        // R5 half loads at odd and even offsets under trap
        do_load(32'h0000_0503, 2'd1, 1'b1);
        do_load(32'h0000_0502, 2'd1, 1'b1);
        // R8 back-to-back split loads without trap
        do_load(32'h0000_0603, 2'd2, 1'b0);
        do_load(32'h0000_0607, 2'd1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule